// File: doc/BRIEF.md
# Reload Down-Counter Timer

The block counts down from a loaded start value, one step for each cycle in which an external tick-enable strobe is high. The strobe stands in for a clock divider that lives elsewhere. Software reaches the block over a simple synchronous register bus, with three registers:

- a control byte, which arms the timer, fires a software start, chooses the mode and the output behaviour, enables the interrupt and holds the underflow flag;
- a reload register, which holds the start value;
- a read-only view of the live count.

Each start copies the reload value into the counter. The counter then counts down, and an underflow happens when a tick arrives while the count is zero. There are two modes:

- **Single-shot:** the timer stops after the underflow.
- **Auto-reload:** the timer copies the reload value back into the counter and keeps running.

Every underflow sets a sticky flag, which becomes an interrupt request when the interrupt enable bit is set. The timer output is a level in single-shot mode and a toggling square wave in auto-reload mode. A separate select output tells the pin multiplexer whether the pin carries the timer output or stays a general-purpose port.

Top module: `reload_timer`

## Requirements
- R1: After reset, the control byte, the reload register and the count all read 0, and `irq`, `tmr_out` and `pin_sel` are 0.
- R2: Register addresses are: 0 = control, 1 = reload (read/write), 2 = count (read-only; writes are ignored), 3 = reads 0. Reads are combinational while `bus_sel` is high, and the bus reads 0 otherwise. The control bits are:
  - bit0: start (write 1 to start)
  - bit1: arm
  - bit2: underflow flag
  - bit3: interrupt enable
  - bit4: auto-reload mode
  - bit5: output level
  - bit6: pin select

  Bit0, bit7 and all bits above bit7 read as 0.
- R3: A control write with bit0=1 and bit1=1 loads the counter from the reload register and starts it, visible the next cycle. A write with bit0=0 starts nothing.
- R4: A control write with bit1=0 stops the counter, and any bit0=1 in that same write is ignored. Setting bit1 without bit0 does not start a stopped counter.
- R5: While running, each tick decrements the count by one. The count holds when the timer is stopped or no tick arrives. A start in the same cycle as a tick takes priority over the decrement.
- R6: A tick at count 0 is an underflow. In single-shot mode the count becomes all ones and the counter stops.
- R7: In auto-reload mode an underflow copies the reload value into the counter, and counting continues.
- R8: An underflow sets the flag. A control write with bit2=0 clears it, and a write with bit2=1 leaves it as it was. If an underflow and a clear happen in the same cycle, the underflow wins.
- R9: `irq` is high exactly while the flag and the interrupt enable bit are both 1.
- R10: In single-shot mode, `tmr_out` is high while running if the output level bit is 0, and low while running if it is 1. When stopped, `tmr_out` takes the opposite level.
- R11: In auto-reload mode, `tmr_out` takes the output level bit's value on each start and inverts on each underflow.
- R12: `pin_sel` follows bit6 of the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data |
| tick_en | input | 1 | One-cycle count strobe |
| irq | output | 1 | Underflow interrupt request |
| tmr_out | output | 1 | Timer output level |
| pin_sel | output | 1 | Pin mux select: 1 = timer output |

## Verification
The bench builds the block with an 8-bit counter (`CNT_W = 8`). With that width, a single-shot underflow lands on 0xFF, which keeps the wrap value short and easy to recognise. Reload values are kept below 6, so underflows, auto-reload restarts and output toggles happen many times within a few thousand random cycles. These random cycles mix starts, stops and flag writes in the same cycle as ticks and underflows, so the priority rules of R4, R5 and R8 are reached repeatedly.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Control byte bit positions (software-visible, fixed)
  localparam int unsigned BIT_START = 0;
  localparam int unsigned BIT_ARM   = 1;
  localparam int unsigned BIT_FLAG  = 2;
  localparam int unsigned BIT_IEN   = 3;
  localparam int unsigned BIT_AUTO  = 4;
  localparam int unsigned BIT_LVL   = 5;
  localparam int unsigned BIT_PSEL  = 6;
  localparam int unsigned CTRL_W    = 8;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_RELOAD = 2'd1,
    RA_COUNT  = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic psel;
    logic lvl;
    logic autold;
    logic ien;
    logic flag;
    logic arm;
  } ctrl_t;

endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ufp_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             start_o,
  output logic             stop_o,
  output logic             start_lvl_o,
  output logic             irq_o
);

  logic             wr_ctrl, wr_rld;
  ctrl_t            ctrl_q, ctrl_n;
  logic [CNT_W-1:0] rld_q, rld_n;
  logic [CTRL_W-1:0] ctrl_rd;
  logic [CNT_W-1:0]  ctrl_wide;

  assign wr_ctrl = bus_sel && bus_we && (reg_addr_e'(bus_addr) == RA_CTRL);
  assign wr_rld  = bus_sel && bus_we && (reg_addr_e'(bus_addr) == RA_RELOAD);

  assign start_o     = wr_ctrl && bus_wdata[BIT_START] && bus_wdata[BIT_ARM];
  assign stop_o      = wr_ctrl && !bus_wdata[BIT_ARM];
  assign start_lvl_o = bus_wdata[BIT_LVL];

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_ctrl) begin
      ctrl_n.arm    = bus_wdata[BIT_ARM];
      ctrl_n.ien    = bus_wdata[BIT_IEN];
      ctrl_n.autold = bus_wdata[BIT_AUTO];
      ctrl_n.lvl    = bus_wdata[BIT_LVL];
      ctrl_n.psel   = bus_wdata[BIT_PSEL];
      if (!bus_wdata[BIT_FLAG]) begin
        ctrl_n.flag = 1'b0;
      end
    end
    if (ufp_i) begin
      ctrl_n.flag = 1'b1;
    end
  end

  always_comb begin
    rld_n = rld_q;
    if (wr_rld) begin
      rld_n = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rld_q  <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      rld_q  <= rld_n;
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[BIT_ARM]  = ctrl_q.arm;
    ctrl_rd[BIT_FLAG] = ctrl_q.flag;
    ctrl_rd[BIT_IEN]  = ctrl_q.ien;
    ctrl_rd[BIT_AUTO] = ctrl_q.autold;
    ctrl_rd[BIT_LVL]  = ctrl_q.lvl;
    ctrl_rd[BIT_PSEL] = ctrl_q.psel;
    ctrl_wide         = '0;
    ctrl_wide[CTRL_W-1:0] = ctrl_rd;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (reg_addr_e'(bus_addr))
        RA_CTRL:   bus_rdata = ctrl_wide;
        RA_RELOAD: bus_rdata = rld_q;
        RA_COUNT:  bus_rdata = cnt_i;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = rld_q;
  assign irq_o    = ctrl_q.flag && ctrl_q.ien;

  // R8: an underflow always leaves the flag set
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ufp_i |=> ctrl_q.flag);

  // R8: writing 1 to the flag bit never clears it
  assert_flag_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[BIT_FLAG] && ctrl_q.flag) |=> ctrl_q.flag);

  // R9: request only while the flag is set
  assert_irq_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ctrl_q.flag && ctrl_q.ien));

endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             autold_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             ufp_o
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             run_q, run_n;
  logic             step, at_zero, ufp;

  assign step    = run_q && tick_i && !start_i && !stop_i;
  assign at_zero = (cnt_q == CNT_ZERO);
  assign ufp     = step && at_zero;

  always_comb begin
    cnt_n = cnt_q;
    run_n = run_q;
    if (stop_i) begin
      run_n = 1'b0;
    end else if (start_i) begin
      cnt_n = reload_i;
      run_n = 1'b1;
    end else if (step) begin
      if (at_zero) begin
        if (autold_i) begin
          cnt_n = reload_i;
        end else begin
          cnt_n = cnt_q - CNT_ONE;
          run_n = 1'b0;
        end
      end else begin
        cnt_n = cnt_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      run_q <= run_n;
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = run_q;
  assign ufp_o     = ufp;

  // R4: a stop always halts the counter
  assert_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !run_q);

  // R3: a start loads the reload value and runs
  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (run_q && cnt_q == $past(reload_i)));

  // R5: counting down by one per tick
  assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  // R5: a stopped counter holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i) |=> $stable(cnt_q));

  // R6: single-shot ends at all ones, stopped
  assert_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ufp && !autold_i) |=> (!run_q && cnt_q == '1));

  // R7: auto-reload keeps running from the reload value
  assert_autold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ufp && autold_i) |=> (run_q && cnt_q == $past(reload_i)));

endmodule

// File: rtl/timer_outgen.sv
module timer_outgen (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic start_lvl_i,
  input  logic ufp_i,
  input  logic autold_i,
  input  logic lvl_i,
  input  logic running_i,
  output logic out_o
);

  logic tog_q, tog_n;
  logic pulse_lvl;

  always_comb begin
    tog_n = tog_q;
    if (start_i) begin
      tog_n = start_lvl_i;
    end else if (ufp_i && autold_i) begin
      tog_n = !tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else begin
      tog_q <= tog_n;
    end
  end

  assign pulse_lvl = running_i ? !lvl_i : lvl_i;
  assign out_o     = autold_i ? tog_q : pulse_lvl;

  // R11: each auto-reload underflow inverts the square wave
  assert_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ufp_i && autold_i && !start_i) |=> (tog_q != $past(tog_q)));

  // R11: start level taken from the written level bit
  assert_startlvl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (tog_q == $past(start_lvl_i)));

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16   // must be at least 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             tick_en,
  output logic             irq,
  output logic             tmr_out,
  output logic             pin_sel
);

  logic             rst_meta_q, rst_sync_q;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload_val, cnt_val;
  logic             start, stop, start_lvl, ufp, running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  timer_regs #(.CNT_W(CNT_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .cnt_i       (cnt_val),
    .ufp_i       (ufp),
    .ctrl_o      (ctrl),
    .reload_o    (reload_val),
    .start_o     (start),
    .stop_o      (stop),
    .start_lvl_o (start_lvl),
    .irq_o       (irq)
  );

  timer_core #(.CNT_W(CNT_W)) core_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .tick_i    (tick_en),
    .start_i   (start),
    .stop_i    (stop),
    .autold_i  (ctrl.autold),
    .reload_i  (reload_val),
    .cnt_o     (cnt_val),
    .running_o (running),
    .ufp_o     (ufp)
  );

  timer_outgen outgen_i (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .start_i     (start),
    .start_lvl_i (start_lvl),
    .ufp_i       (ufp),
    .autold_i    (ctrl.autold),
    .lvl_i       (ctrl.lvl),
    .running_i   (running),
    .out_o       (tmr_out)
  );

  assign pin_sel = ctrl.psel;

  // R4: the counter never runs while disarmed
  assert_run_armed_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    running |-> ctrl.arm);

  // R10: single-shot output polarity while counting
  assert_level_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (running && !ctrl.autold) |-> (tmr_out != ctrl.lvl));

  // R12: pin select follows the written bit
  assert_psel_R12: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bus_sel && bus_we && bus_addr == 2'd0) |=> (pin_sel == $past(bus_wdata[BIT_PSEL])));

endmodule

// File: tb/reload_timer_tb_top.sv
`timescale 1ns/1ps
module reload_timer_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_sel, bus_we, tick_en;
  logic [1:0]   bus_addr;
  logic [W-1:0] bus_wdata, bus_rdata;
  logic         irq, tmr_out, pin_sel;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic         m_arm, m_flag, m_ien, m_auto, m_lvl, m_psel, m_run, m_tog;
  logic [W-1:0] m_rl, m_cnt;

  always #4 clk = ~clk;

  reload_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq), .tmr_out(tmr_out), .pin_sel(pin_sel)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_rdata();
    if (!bus_sel) return '0;
    case (bus_addr)
      2'd0: return W'({1'b0, m_psel, m_lvl, m_auto, m_ien, m_flag, m_arm, 1'b0});
      2'd1: return m_rl;
      2'd2: return m_cnt;
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_out();
    if (m_auto) return m_tog;
    return m_run ? !m_lvl : m_lvl;
  endfunction

  task automatic model_reset();
    {m_arm, m_flag, m_ien, m_auto, m_lvl, m_psel, m_run, m_tog} = '0;
    m_rl = '0; m_cnt = '0;
  endtask

  task automatic model_step();
    logic wc, start, stop, step, ufp;
    logic [W-1:0] cnt_n; logic run_n, tog_n, flag_n;
    wc    = bus_sel && bus_we && bus_addr == 2'd0;
    start = wc && bus_wdata[0] && bus_wdata[1];
    stop  = wc && !bus_wdata[1];
    step  = m_run && tick_en && !start && !stop;
    ufp   = step && m_cnt == '0;
    cnt_n = m_cnt; run_n = m_run; tog_n = m_tog; flag_n = m_flag;
    if (stop) run_n = 1'b0;
    else if (start) begin cnt_n = m_rl; run_n = 1'b1; end
    else if (step) begin
      if (ufp && m_auto) cnt_n = m_rl;
      else cnt_n = m_cnt - 1'b1;
      if (ufp && !m_auto) run_n = 1'b0;
    end
    if (start) tog_n = bus_wdata[5];
    else if (ufp && m_auto) tog_n = !m_tog;
    if (wc && !bus_wdata[2]) flag_n = 1'b0;
    if (ufp) flag_n = 1'b1;
    if (wc) begin
      m_arm = bus_wdata[1]; m_ien = bus_wdata[3]; m_auto = bus_wdata[4];
      m_lvl = bus_wdata[5]; m_psel = bus_wdata[6];
    end
    if (bus_sel && bus_we && bus_addr == 2'd1) m_rl = bus_wdata;
    m_cnt = cnt_n; m_run = run_n; m_tog = tog_n; m_flag = flag_n;
  endtask

  // one clock: drive, advance reference at the edge, compare mid-cycle
  task automatic cyc(input logic s, input logic we, input logic [1:0] a,
                     input logic [W-1:0] d, input logic t);
    bus_sel = s; bus_we = we; bus_addr = a; bus_wdata = d; tick_en = t;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R2/R5/R8 rdata", bus_rdata, exp_rdata());
    check("R9 irq", W'(irq), W'(m_flag && m_ien));
    check("R10/R11 tmr_out", W'(tmr_out), W'(exp_out()));
    check("R12 pin_sel", W'(pin_sel), W'(m_psel));
  endtask

  task automatic peek(input logic [1:0] a, output logic [W-1:0] v);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; tick_en = 1'b0;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, '0, 1'b1);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; tick_en = 0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc(1'b0, 1'b0, 2'd0, '0, 1'b0);

    // R1 reset values
    peek(2'd0, v); check("R1 ctrl", v, 8'h00);
    peek(2'd1, v); check("R1 reload", v, 8'h00);
    peek(2'd2, v); check("R1 count", v, 8'h00);
    check("R1 irq/out/psel", W'({irq, tmr_out, pin_sel}), 8'h00);

    // R2 reload readback, R3 start
    wr(2'd1, 8'd3);
    peek(2'd1, v); check("R2 reload rw", v, 8'd3);
    wr(2'd0, 8'h0A);                        // arm, no start
    tick(2);
    peek(2'd2, v); check("R4 arm alone does not start", v, 8'd0);
    wr(2'd0, 8'h0B);                        // start, ien
    peek(2'd2, v); check("R3 start loads reload", v, 8'd3);
    check("R10 high while running", W'(tmr_out), 8'd1);
    tick(3);
    peek(2'd2, v); check("R5 three ticks", v, 8'd0);
    tick(1);
    peek(2'd2, v); check("R6 single-shot wrap", v, 8'hFF);
    check("R9 irq on underflow", W'(irq), 8'd1);
    check("R10 idle level", W'(tmr_out), 8'd0);
    tick(2);
    peek(2'd2, v); check("R6 stopped after underflow", v, 8'hFF);

    // R8 flag write semantics
    wr(2'd0, 8'h0E);
    peek(2'd0, v); check("R8 write 1 keeps flag", v & 8'h04, 8'h04);
    wr(2'd0, 8'h0A);
    peek(2'd0, v); check("R8 write 0 clears flag", v & 8'h04, 8'h00);
    check("R9 irq drops", W'(irq), 8'd0);

    // R4 start with arm clear ignored; R2 count write ignored; bit0/bit7 read 0
    wr(2'd0, 8'h81);
    tick(2);
    peek(2'd2, v); check("R4 start with arm=0 ignored", v, 8'hFF);
    peek(2'd0, v); check("R2 bit0/bit7 read 0", v, 8'h00);
    wr(2'd2, 8'h55);
    peek(2'd2, v); check("R2 count write ignored", v, 8'hFF);

    // R7/R11 auto-reload, R12 pin select
    wr(2'd1, 8'd1);
    wr(2'd0, 8'h73);
    check("R11 start level", W'(tmr_out), 8'd1);
    check("R12 pin_sel set", W'(pin_sel), 8'd1);
    tick(2);
    peek(2'd2, v); check("R7 reloaded", v, 8'd1);
    check("R11 toggled", W'(tmr_out), 8'd0);
    tick(2);
    check("R11 toggled back", W'(tmr_out), 8'd1);
    peek(2'd0, v); check("R7 still armed with flag", v, 8'h76);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic s, we, t; logic [1:0] a; logic [W-1:0] d;
      s  = ($urandom % 3) != 0;
      we = $urandom % 2;
      a  = 2'($urandom % 4);
      d  = W'($urandom);
      if (a == 2'd1) d = W'($urandom % 6);
      if (a == 2'd0) d[1] = ($urandom % 8) != 0;
      t  = $urandom % 2;
      cyc(s, we, a, d, t);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule